// File: doc/BRIEF.md
# Windowed Rectify-and-Integrate Accumulator

This block turns a stream of signed, already filtered samples into one energy figure per measurement window. Each sample that arrives while the window input is high is folded to its magnitude. It is then multiplied by the reciprocal of a selectable time constant, and the product is added to a fixed-point accumulator. The host opens a window by raising the window input, and the accumulator starts again from zero. When the host lowers the window input, the integer part of the accumulator is copied into a holding register. That register drives the result output until the next window closes, so a reader never sees a value that is still changing.

Each valid sample represents one 5 µs sample period. The per-sample weight is therefore 5 µs divided by the chosen time constant, which is picked from a fixed, non-uniform list of 32 values by a 5-bit code. Saturation is built into the adder, so any window length, including windows far longer than 10 ms, can run without wrapping. A sticky flag records that full scale was reached during the current window.

Top module: `rect_integrator`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released, `result_o` is 0 and `clamp_o` is 0.
- R2: A sample contributes by its magnitude only: x and −x add the same amount. The most negative code −2^(SAMPLE_W−1) counts as magnitude 2^(SAMPLE_W−1).
- R3: Each accepted sample adds floor(|x| · K(c) / 2^(RECIP_FRAC−FRAC_W)) to an accumulator that has FRAC_W fractional bits, where K(c) = floor((5·2^RECIP_FRAC + τ(c)/2) / τ(c)). The result is the accumulator's integer part, which is the accumulator shifted right by FRAC_W.
- R4: τ(c) in µs for code c = 0..31 is 40, 45, 50, 55, 60, 65, 70, 75, 80 for c = 0..8; then 90 to 160 in steps of 10 for c = 9..16; then 180 to 320 in steps of 20 for c = 17..24; then 360 to 600 in steps of 40 for c = 25..31.
- R5: A sample is accumulated only in a clock cycle where both `win_i` and `smp_valid_i` are high. This includes the cycle in which `win_i` first goes high. Samples with `smp_valid_i` low, or with `win_i` low, change nothing.
- R6: When a window opens, the accumulator restarts from zero. A window that closes with no accepted samples reports 0.
- R7: `result_o` changes only on the clock edge where `win_i` is first seen low after being high. It then shows the integer part of the accumulator at that moment. At all other times it keeps its value, including during the next window.
- R8: The accumulator saturates at 2^(RESULT_W+FRAC_W)−1 instead of wrapping. A saturated window reports 2^RESULT_W−1.
- R9: `clamp_o` rises on the edge where an addition would pass full scale. It stays high through the rest of that window and the hold period, and it clears on the edge where the next window opens.
- R10: A window of 2000 full-magnitude samples (10 ms) ends with a saturated, non-wrapped result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Strobe marking a new sample, one cycle per sample period |
| smp_i | input | SAMPLE_W | Signed filtered sample, two's complement |
| win_i | input | 1 | Integration window, high = integrate, low = hold |
| tc_code_i | input | 5 | Time-constant code, selects τ(c) |
| result_o | output | RESULT_W | Held integer result of the last closed window |
| clamp_o | output | 1 | Sticky saturation flag of the current window |

## Verification
The bench builds the block with 8-bit samples, a 6-bit result, 8 fractional bits and a 16-bit reciprocal fraction. With these values a single full-magnitude sample adds up to 16 result counts, so saturation is reached within a few dozen samples at short time constants but not at the longest ones. Both sides of the clamp boundary can therefore be swept over all 32 codes, and the single-sample sweep covers every code against a spread of positive, negative and extreme sample values. The narrow result also lets a 10 ms window be run in full to show saturation without wrap.

// File: rtl/ri_pkg.sv
package ri_pkg;

   // number of selectable time constants and the code width that picks one
   localparam int unsigned RI_CODES = 32;
   localparam int unsigned RI_TC_W  = $clog2(RI_CODES);

   // sample period in microseconds; one valid strobe stands for this span
   localparam int unsigned RI_PERIOD_US = 5;

   // time constant in microseconds, four linear segments of growing stride
   function automatic int unsigned ri_tau_us(input int unsigned code);
      int unsigned t;
      if (code <= 8)       t = 40  + 5  * code;
      else if (code <= 16) t = 90  + 10 * (code - 9);
      else if (code <= 24) t = 180 + 20 * (code - 17);
      else                 t = 360 + 40 * (code - 25);
      return t;
   endfunction

   // rounded fixed-point value of period/tau with frac fractional bits
   function automatic int unsigned ri_recip(input int unsigned tau, input int unsigned frac);
      return ((RI_PERIOD_US << frac) + tau / 2) / tau;
   endfunction

endpackage

// File: rtl/ri_window.sv
module ri_window (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic win_i,
   output logic open_o,
   output logic close_o,
   output logic active_o
);

   logic win_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) win_q <= 1'b0;
      else         win_q <= win_i;
   end

   assign open_o   = win_i & ~win_q;
   assign close_o  = ~win_i & win_q;
   assign active_o = win_i;

endmodule

// File: rtl/ri_rectify.sv
module ri_rectify #(
   parameter int unsigned SAMPLE_W = 10
) (
   input  logic signed [SAMPLE_W-1:0] smp_i,
   output logic        [SAMPLE_W-1:0] mag_o
);

   logic [SAMPLE_W-1:0] raw;
   logic [SAMPLE_W-1:0] neg;

   assign raw = smp_i;
   assign neg = ~raw + SAMPLE_W'(1);

   // the most negative code negates onto itself, which read unsigned is 2^(W-1)
   assign mag_o = raw[SAMPLE_W-1] ? neg : raw;

endmodule

// File: rtl/ri_scale.sv
module ri_scale
   import ri_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 10,
   parameter int unsigned FRAC_W     = 8,
   parameter int unsigned RECIP_FRAC = 16,
   localparam int unsigned RECIP_W   = RECIP_FRAC - 2,
   localparam int unsigned PROD_W    = SAMPLE_W + RECIP_W,
   localparam int unsigned SHIFT     = RECIP_FRAC - FRAC_W,
   localparam int unsigned INC_W     = PROD_W - SHIFT
) (
   input  logic [SAMPLE_W-1:0] mag_i,
   input  logic [RI_TC_W-1:0]  code_i,
   output logic [INC_W-1:0]    inc_o
);

   logic [RECIP_W-1:0] recip_tbl [RI_CODES];
   logic [RECIP_W-1:0] recip_sel;
   logic [PROD_W-1:0]  prod;

   // reciprocal table built from the time-constant law, one constant per code
   for (genvar g = 0; g < RI_CODES; g++) begin : g_recip
      assign recip_tbl[g] = RECIP_W'(ri_recip(ri_tau_us(g), RECIP_FRAC));
   end

   assign recip_sel = recip_tbl[code_i];
   assign prod      = PROD_W'(mag_i) * PROD_W'(recip_sel);

   // drop the reciprocal bits below the accumulator's fractional resolution
   if (SHIFT == 0) begin : g_noshift
      assign inc_o = INC_W'(prod);
   end else begin : g_shift
      assign inc_o = INC_W'(prod >> SHIFT);
   end

endmodule

// File: rtl/ri_accum.sv
module ri_accum #(
   parameter int unsigned ACC_W = 18,
   parameter int unsigned INC_W = 16,
   localparam int unsigned SUM_W = ((INC_W > ACC_W) ? INC_W : ACC_W) + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             open_i,
   input  logic             take_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             clamp_o
);

   localparam logic [SUM_W-1:0] FULL = SUM_W'({ACC_W{1'b1}});

   logic [ACC_W-1:0] acc_q;
   logic             clamp_q;
   logic [SUM_W-1:0] base;
   logic [SUM_W-1:0] addend;
   logic [SUM_W-1:0] sum;
   logic             over;
   logic [ACC_W-1:0] acc_d;
   logic             clamp_d;

   always_comb begin
      base    = open_i ? '0 : SUM_W'(acc_q);
      addend  = take_i ? SUM_W'(inc_i) : '0;
      sum     = base + addend;
      over    = (sum > FULL);
      acc_d   = over ? ACC_W'(FULL) : ACC_W'(sum);
      clamp_d = (open_i ? 1'b0 : clamp_q) | over;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q   <= '0;
         clamp_q <= 1'b0;
      end else begin
         acc_q   <= acc_d;
         clamp_q <= clamp_d;
      end
   end

   assign acc_o   = acc_q;
   assign clamp_o = clamp_q;

endmodule

// File: rtl/ri_hold.sv
module ri_hold #(
   parameter int unsigned ACC_W    = 18,
   parameter int unsigned FRAC_W   = 8,
   parameter int unsigned RESULT_W = 10
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                close_i,
   input  logic [ACC_W-1:0]    acc_i,
   output logic [RESULT_W-1:0] result_o
);

   logic [RESULT_W-1:0] res_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      res_q <= '0;
      else if (close_i) res_q <= RESULT_W'(acc_i >> FRAC_W);
   end

   assign result_o = res_q;

endmodule

// File: rtl/rect_integrator.sv
module rect_integrator
   import ri_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 10,
   parameter int unsigned RESULT_W   = 10,
   parameter int unsigned FRAC_W     = 8,
   parameter int unsigned RECIP_FRAC = 16
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       smp_valid_i,
   input  logic signed [SAMPLE_W-1:0] smp_i,
   input  logic                       win_i,
   input  logic [RI_TC_W-1:0]         tc_code_i,
   output logic [RESULT_W-1:0]        result_o,
   output logic                       clamp_o
);

   localparam int unsigned ACC_W   = RESULT_W + FRAC_W;
   localparam int unsigned RECIP_W = RECIP_FRAC - 2;
   localparam int unsigned INC_W   = SAMPLE_W + RECIP_W - (RECIP_FRAC - FRAC_W);

   // elaboration-time parameter checks
   if (SAMPLE_W < 2) begin : g_chk_sample
      $error("rect_integrator: SAMPLE_W must be at least 2");
   end
   if (RESULT_W < 1) begin : g_chk_result
      $error("rect_integrator: RESULT_W must be at least 1");
   end
   if (FRAC_W < 8) begin : g_chk_frac
      $error("rect_integrator: FRAC_W must be at least 8");
   end
   if (RECIP_FRAC < FRAC_W || RECIP_FRAC < 4 || RECIP_FRAC > 24) begin : g_chk_recip
      $error("rect_integrator: RECIP_FRAC must lie in [max(FRAC_W,4), 24]");
   end

   logic                open_p;
   logic                close_p;
   logic                active;
   logic [SAMPLE_W-1:0] mag;
   logic [INC_W-1:0]    inc;
   logic [ACC_W-1:0]    acc;

   ri_window u_window (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .win_i    (win_i),
      .open_o   (open_p),
      .close_o  (close_p),
      .active_o (active)
   );

   ri_rectify #(.SAMPLE_W(SAMPLE_W)) u_rectify (
      .smp_i (smp_i),
      .mag_o (mag)
   );

   ri_scale #(
      .SAMPLE_W   (SAMPLE_W),
      .FRAC_W     (FRAC_W),
      .RECIP_FRAC (RECIP_FRAC)
   ) u_scale (
      .mag_i  (mag),
      .code_i (tc_code_i),
      .inc_o  (inc)
   );

   ri_accum #(
      .ACC_W (ACC_W),
      .INC_W (INC_W)
   ) u_accum (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .open_i  (open_p),
      .take_i  (active & smp_valid_i),
      .inc_i   (inc),
      .acc_o   (acc),
      .clamp_o (clamp_o)
   );

   ri_hold #(
      .ACC_W    (ACC_W),
      .FRAC_W   (FRAC_W),
      .RESULT_W (RESULT_W)
   ) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .close_i  (close_p),
      .acc_i    (acc),
      .result_o (result_o)
   );

endmodule

// File: rtl/ri_checker.sv
module ri_checker #(
   parameter int unsigned RESULT_W = 10
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                win_i,
   input logic                smp_valid_i,
   input logic [RESULT_W-1:0] result_o,
   input logic                clamp_o
);

   AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$fell(win_i) |=> $stable(result_o)); // R7

   AST_CLAMP_CLEARS_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(win_i) && !smp_valid_i) |=> !clamp_o); // R9

   AST_CLAMP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clamp_o && !$rose(win_i)) |=> clamp_o); // R9

   AST_SATURATED_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(win_i) && clamp_o) |=> (result_o == {RESULT_W{1'b1}})); // R8

   AST_NO_CLAMP_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!win_i && !clamp_o) |=> !clamp_o); // R5

endmodule

bind rect_integrator ri_checker #(.RESULT_W(RESULT_W)) u_ri_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .win_i       (win_i),
   .smp_valid_i (smp_valid_i),
   .result_o    (result_o),
   .clamp_o     (clamp_o)
);

// File: tb/rect_integrator_test.sv
`timescale 1ns/1ps
module rect_integrator_test;

   localparam int SW = 8;
   localparam int RW = 6;
   localparam int FW = 8;
   localparam int RF = 16;
   localparam int FS = (1 << (RW + FW)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vld = 1'b0;
   logic [SW-1:0] smp = '0;
   logic          win = 1'b0;
   logic [4:0]    tc = '0;
   logic [RW-1:0] result;
   logic          clamp;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   rect_integrator #(
      .SAMPLE_W(SW), .RESULT_W(RW), .FRAC_W(FW), .RECIP_FRAC(RF)
   ) uut (
      .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vld), .smp_i(smp),
      .win_i(win), .tc_code_i(tc), .result_o(result), .clamp_o(clamp)
   );

   // time constants from R4, written out independently
   int taus [32] = '{40, 45, 50, 55, 60, 65, 70, 75, 80,
                     90, 100, 110, 120, 130, 140, 150, 160,
                     180, 200, 220, 240, 260, 280, 300, 320,
                     360, 400, 440, 480, 520, 560, 600};

   function automatic int inc_of(int x, int c);
      int m, k;
      m = (x < 0) ? -x : x;
      k = ((5 << RF) + taus[c] / 2) / taus[c];
      return (m * k) >> (RF - FW);
   endfunction

   // cycle model of R3, R5, R6, R7, R8, R9
   int m_acc = 0, m_res = 0;
   bit m_clamp = 0, m_winq = 0;
   always @(posedge clk or negedge rst_n) begin
      int s;
      bit cl;
      if (!rst_n) begin
         m_acc <= 0; m_res <= 0; m_clamp <= 0; m_winq <= 0;
      end else begin
         s  = (win && !m_winq) ? 0 : m_acc;
         cl = (win && !m_winq) ? 1'b0 : m_clamp;
         if (win && vld) begin
            s = s + inc_of(int'($signed(smp)), int'(tc));
            if (s > FS) begin s = FS; cl = 1'b1; end
         end
         if (!win && m_winq) m_res <= m_acc >> FW;
         m_acc <= s; m_clamp <= cl; m_winq <= win;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(bit w, bit v, int x);
      @(negedge clk);
      win = w; vld = v; smp = SW'(x);
   endtask

   task automatic look(string tag);
      @(negedge clk);
      chk({tag, " result"}, int'(result), m_res);
      chk({tag, " clamp"}, int'(clamp), int'(m_clamp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   int pts [10] = '{-128, -127, -77, -9, -1, 0, 1, 50, 100, 127};

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 result in reset", int'(result), 0);
      chk("R1 clamp in reset", int'(clamp), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 result after reset", int'(result), 0);
      chk("R1 clamp after reset", int'(clamp), 0);

      // R2 R3 R4: single-sample windows, every code, spread of sample values
      for (int c = 0; c < 32; c++) begin
         for (int i = 0; i < 10; i++) begin
            tc = 5'(c);
            cyc(1, 1, pts[i]);
            cyc(0, 0, 0);
            @(negedge clk);
            chk($sformatf("R3 R4 code %0d x %0d", c, pts[i]), int'(result),
                inc_of(pts[i], c) >> FW);
            chk("R2 clamp single", int'(clamp), 0);
            cyc(1, 1, -pts[i] == 128 ? 127 : -pts[i]);
            cyc(0, 0, 0);
            @(negedge clk);
            chk($sformatf("R2 mirror code %0d x %0d", c, pts[i]), int'(result),
                inc_of(-pts[i] == 128 ? 127 : -pts[i], c) >> FW);
         end
      end

      // R8 R9: 50 full-magnitude samples, clamp boundary swept across codes
      for (int c = 0; c < 32; c++) begin
         int tot;
         tc = 5'(c);
         tot = 50 * inc_of(-128, c);
         for (int k = 0; k < 50; k++) cyc(1, 1, -128);
         cyc(0, 0, 0);
         @(negedge clk);
         chk($sformatf("R8 code %0d result", c), int'(result), ((tot > FS) ? FS : tot) >> FW);
         chk($sformatf("R9 code %0d clamp", c), int'(clamp), (tot > FS) ? 1 : 0);
      end

      // R9 R7 R6: saturate, then reopen: clamp clears, result holds, then reports 0
      tc = 5'd0;
      for (int k = 0; k < 10; k++) cyc(1, 1, 127);
      cyc(0, 0, 0);
      look("R8 saturate");
      chk("R8 full scale", int'(result), (1 << RW) - 1);
      cyc(0, 1, 90);
      cyc(0, 1, -90);
      look("R5 samples outside window");
      chk("R7 held after idle samples", int'(result), (1 << RW) - 1);
      chk("R9 clamp held in hold period", int'(clamp), 1);
      cyc(1, 0, 0);
      look("R9 reopen");
      chk("R9 clamp cleared on open", int'(clamp), 0);
      chk("R7 result held while open", int'(result), (1 << RW) - 1);
      cyc(1, 0, 55);
      cyc(0, 0, 0);
      look("R6 empty window");
      chk("R6 empty window reports zero", int'(result), 0);

      // R5: valid gating inside a window, mixed patterns with the model
      tc = 5'd13;
      for (int k = 0; k < 24; k++) cyc(1, k[0], (k * 37 % 255) - 127);
      look("R7 mid window");
      cyc(0, 0, 0);
      look("R5 gated window");
      tc = 5'd26;
      for (int k = 0; k < 30; k++) cyc(1, (k % 3) != 0, 120 - 8 * k);
      cyc(0, 0, 0);
      look("R3 varied samples");

      // R10: 2000 samples at the longest time constant
      tc = 5'd31;
      for (int k = 0; k < 2000; k++) cyc(1, 1, 127);
      cyc(0, 0, 0);
      look("R10 long window");
      chk("R10 long window saturates", int'(result), (1 << RW) - 1);
      chk("R10 long window clamp", int'(clamp), 1);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule